// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of an SDRAM read or write burst. It sits inside a memory model or a controller, next to the logic that owns the banks and the data path. A mode-load strobe writes a small key into an internal mode register. The key sets the burst length, the beat ordering, the read latency and a write-length override. A column command then supplies a 10-bit start column. From the next clock on, the block emits one column per cycle until the burst is complete, stopped or replaced.

Fixed-length bursts stay inside an aligned block of the burst length. In sequential order the column counts upward and wraps inside that block. In interleaved order the low column bits are the start offset XORed with the beat number. A full-page burst walks the whole 1024-column row, wrapping at its end, and runs until something ends it. The final beat of a fixed-length burst is flagged. A burst-stop command, or a new column command, cuts a burst short on any beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low and after its release, `col_valid` and `col_last` are 0 and `cas_lat` reads 3. The mode register holds length code 000, sequential order and write override off.
- R2: A `mode_load` pulse copies key fields into the mode register: bits 2:0 = length code, bit 3 = order (0 sequential, 1 interleaved), bits 6:4 = read latency, bit 9 = single-beat writes. `cas_lat` shows the new latency in the cycle after the load. Latency codes other than 010 (2) and 011 (3) leave `cas_lat` unchanged.
- R3: A `col_start` sampled at a clock edge makes `col_out` equal `col_addr` with `col_valid` high right after that edge. Each later edge advances the burst by one beat.
- R4: Length codes 001, 010 and 011 give 2, 4 and 8 beats. In sequential order, beat i is the start column with its low log2(length) bits replaced by (start + i) modulo the length.
- R5: In interleaved order, beat i is the start column with its low log2(length) bits replaced by (start offset XOR i).
- R6: `col_last` is high exactly on the final beat of a fixed-length burst. `col_valid` is 0 in the cycle after that beat unless a new command arrives.
- R7: Length code 111 selects full page. Beat i is (start + i) modulo 1024 whatever the order bit says. `col_last` never rises, and the burst continues past 1024 beats until it is ended.
- R8: A `burst_stop` sampled at an edge with no `col_start` makes `col_valid` 0 after that edge. With no burst running it has no visible effect.
- R9: A `col_start` during a burst abandons it and begins the new burst after the same edge. When it coincides with `burst_stop`, the new command wins.
- R10: With bit 9 set, a command with `col_wr` high yields a single beat. Commands with `col_wr` low still use the programmed length.
- R11: Length, order and override are captured when a burst starts. A `mode_load` during the burst does not alter its remaining beats.
- R12: Length codes 100, 101 and 110, and the reset length code 000, give a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_load | input | 1 | Writes `mode_key` into the mode register |
| mode_key | input | KEY_W (13) | Mode key: length, order, latency, write override |
| col_start | input | 1 | Column command strobe (read or write) |
| col_wr | input | 1 | The command is a write |
| col_addr | input | COL_W (10) | Start column of the command |
| burst_stop | input | 1 | Burst-stop command |
| col_valid | output | 1 | A burst beat is present on `col_out` |
| col_out | output | COL_W (10) | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |
| cas_lat | output | 3 | Programmed read latency in clocks (2 or 3) |

## Verification
Every result follows a command by exactly one edge. The first column appears right after the edge that samples `col_start`, and `cas_lat` changes right after the edge that samples `mode_load`. A stop or a completed burst clears `col_valid` after its edge. The bench drives inputs on the falling edge. It samples each output at the following falling edge, so each read falls half a period after the edge that produced the value, and beat i is read i full cycles after the first beat. Every point where a burst is interrupted, re-programmed or stopped is timed against that same grid.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Key field positions; the decoders below depend on them.
  localparam int KEY_LEN_LSB  = 0;
  localparam int KEY_ORDER    = 3;
  localparam int KEY_LAT_LSB  = 4;
  localparam int KEY_WR_ONE   = 9;
  localparam int KEY_MIN_W    = 10;

  localparam logic [2:0] LEN_FULL = 3'b111;
  localparam logic [2:0] LAT_TWO  = 3'd2;
  localparam logic [2:0] LAT_THREE = 3'd3;

  // Burst span: full-page flag plus log2 of a fixed length.
  typedef struct packed {
    logic       full;
    logic [3:0] lg;
  } span_t;

  function automatic span_t span_decode(input logic [2:0] code);
    span_t s;
    s.full = 1'b0;
    s.lg   = 4'd0;
    case (code)
      3'b001:   s.lg = 4'd1;
      3'b010:   s.lg = 4'd2;
      3'b011:   s.lg = 4'd3;
      LEN_FULL: s.full = 1'b1;
      default:  s.lg = 4'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
#(
  parameter int KEY_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output logic [2:0]       len_code,
  output logic             order_ilv,
  output logic [2:0]       lat,
  output logic             wr_one
);

  logic [2:0] len_d, len_q;
  logic       ilv_d, ilv_q;
  logic [2:0] lat_d, lat_q;
  logic       one_d, one_q;
  logic [2:0] lat_key;

  assign lat_key = key[KEY_LAT_LSB +: 3];

  always_comb begin
    len_d = len_q;
    ilv_d = ilv_q;
    lat_d = lat_q;
    one_d = one_q;
    if (load) begin
      len_d = key[KEY_LEN_LSB +: 3];
      ilv_d = key[KEY_ORDER];
      one_d = key[KEY_WR_ONE];
      if (lat_key == LAT_TWO || lat_key == LAT_THREE) begin
        lat_d = lat_key;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 3'b000;
      ilv_q <= 1'b0;
      lat_q <= LAT_THREE;
      one_q <= 1'b0;
    end else begin
      len_q <= len_d;
      ilv_q <= ilv_d;
      lat_q <= lat_d;
      one_q <= one_d;
    end
  end

  assign len_code  = len_q;
  assign order_ilv = ilv_q;
  assign lat       = lat_q;
  assign wr_one    = one_q;

  // R2: only the two supported latencies can ever be held
  p_lat_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q == LAT_TWO) || (lat_q == LAT_THREE));

  // R2: a load with a supported latency code is reflected next cycle
  p_lat_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (lat_key == LAT_TWO || lat_key == LAT_THREE)) |=> (lat_q == $past(lat_key)));

endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             is_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             order_ilv,
  input  logic             wr_one,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             ilv
);

  span_t            span_new;
  logic [COL_W-1:0] mask_new;

  logic             act_d, act_q;
  logic [COL_W-1:0] cnt_d, cnt_q;
  logic [COL_W-1:0] base_d, base_q;
  logic [COL_W-1:0] mask_d, mask_q;
  logic             ilv_d, ilv_q;
  logic             full_d, full_q;
  logic             last_w;

  // Span for a command arriving now; write override and reserved codes -> 1 beat
  always_comb begin
    span_new = span_decode(len_code);
    if (is_wr && wr_one) begin
      span_new.full = 1'b0;
      span_new.lg   = 4'd0;
    end
  end

  // Low-bit mask of the burst block, one bit per column bit
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_new[b] = span_new.full | (span_new.lg > 4'(b));
  end

  assign last_w = act_q && !full_q && (cnt_q == mask_q);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    full_d = full_q;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      base_d = start_col;
      mask_d = mask_new;
      ilv_d  = order_ilv && !span_new.full;
      full_d = span_new.full;
    end else if (stop) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (last_w) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      full_q <= full_d;
    end
  end

  assign active = act_q;
  assign last   = last_w;
  assign base   = base_q;
  assign beat   = cnt_q;
  assign mask   = mask_q;
  assign ilv    = ilv_q;

  // R3: a command starts a fresh burst at beat zero with its own column
  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && cnt_q == '0 && base_q == $past(start_col)));

  // R3: a running burst that is not ended advances by one beat
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start && !stop && !last_w) |=> (act_q && cnt_q == $past(cnt_q) + 1'b1));

  // R8: stop without a new command ends the burst
  p_stop_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !act_q);

  // R6: after the final beat the burst is over unless restarted
  p_last_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !start) |=> !act_q);

  // R11: burst parameters hold while no command arrives
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start) |=> ($stable(mask_q) && $stable(ilv_q) && $stable(base_q)));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;

  assign sum = base + beat;

  // Bits inside the block follow the order; bits above it keep the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (ilv ? (base[b] ^ beat[b]) : sum[b]) : base[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int KEY_W = 13,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             col_start,
  input  logic             col_wr,
  input  logic [COL_W-1:0] col_addr,
  input  logic             burst_stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_out,
  output logic             col_last,
  output logic [2:0]       cas_lat
);

  logic [2:0]       len_code;
  logic             order_ilv;
  logic             wr_one;
  logic             active;
  logic             last;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask;
  logic             ilv;
  logic [COL_W-1:0] col;

  initial begin
    if (KEY_W < KEY_MIN_W) $error("KEY_W too small for the mode fields");
  end

  burst_mode_reg #(.KEY_W(KEY_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (mode_load),
    .key       (mode_key),
    .len_code  (len_code),
    .order_ilv (order_ilv),
    .lat       (cas_lat),
    .wr_one    (wr_one)
  );

  burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (col_start),
    .stop      (burst_stop),
    .is_wr     (col_wr),
    .start_col (col_addr),
    .len_code  (len_code),
    .order_ilv (order_ilv),
    .wr_one    (wr_one),
    .active    (active),
    .last      (last),
    .base      (base),
    .beat      (beat),
    .mask      (mask),
    .ilv       (ilv)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .beat (beat),
    .mask (mask),
    .ilv  (ilv),
    .col  (col)
  );

  assign col_valid = active;
  assign col_out   = col;
  assign col_last  = last;

  // R4: every emitted column stays inside the aligned block of the burst
  p_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (((col_out ^ base) & ~mask) == '0));

  // R6: the final-beat flag only accompanies a valid beat
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int KEY_W = 13;
  localparam int COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic             mode_load;
  logic [KEY_W-1:0] mode_key;
  logic             col_start;
  logic             col_wr;
  logic [COL_W-1:0] col_addr;
  logic             burst_stop;
  logic             col_valid;
  logic [COL_W-1:0] col_out;
  logic             col_last;
  logic [2:0]       cas_lat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sdram_burst_colgen #(.KEY_W(KEY_W), .COL_W(COL_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_load  (mode_load),
    .mode_key   (mode_key),
    .col_start  (col_start),
    .col_wr     (col_wr),
    .col_addr   (col_addr),
    .burst_stop (burst_stop),
    .col_valid  (col_valid),
    .col_out    (col_out),
    .col_last   (col_last),
    .cas_lat    (cas_lat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [12:0]      key;
    logic [9:0]       col;
    logic             wr;
    logic [3:0]       n;
    logic [2:0]       cl;
    logic [0:7][9:0]  a;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{13'h033, 10'h0D5, 1'b0, 4'd8, 3'd3, {10'h0D5,10'h0D6,10'h0D7,10'h0D0,10'h0D1,10'h0D2,10'h0D3,10'h0D4}}, // R4 len8 seq
    '{13'h03B, 10'h0D5, 1'b0, 4'd8, 3'd3, {10'h0D5,10'h0D4,10'h0D7,10'h0D6,10'h0D1,10'h0D0,10'h0D3,10'h0D2}}, // R5 len8 ilv
    '{13'h022, 10'h3FE, 1'b0, 4'd4, 3'd2, {10'h3FE,10'h3FF,10'h3FC,10'h3FD,40'h0}},                         // R4 len4 seq
    '{13'h02A, 10'h101, 1'b0, 4'd4, 3'd2, {10'h101,10'h100,10'h103,10'h102,40'h0}},                         // R5 len4 ilv
    '{13'h031, 10'h007, 1'b0, 4'd2, 3'd3, {10'h007,10'h006,60'h0}},                                         // R4 len2 seq
    '{13'h030, 10'h2AA, 1'b0, 4'd1, 3'd3, {10'h2AA,70'h0}},                                                 // R12 len1
    '{13'h233, 10'h015, 1'b1, 4'd1, 3'd3, {10'h015,70'h0}},                                                 // R10 write override
    '{13'h233, 10'h015, 1'b0, 4'd8, 3'd3, {10'h015,10'h016,10'h017,10'h010,10'h011,10'h012,10'h013,10'h014}}, // R10 read still bursts
    '{13'h035, 10'h0F3, 1'b0, 4'd1, 3'd3, {10'h0F3,70'h0}}                                                  // R12 reserved code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_mode(input logic [KEY_W-1:0] k);
    mode_load = 1'b1;
    mode_key  = k;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic start_cmd(input logic [COL_W-1:0] c, input logic w);
    col_start = 1'b1;
    col_addr  = c;
    col_wr    = w;
    @(negedge clk);
    col_start = 1'b0;
    col_wr    = 1'b0;
  endtask

  task automatic stop_cmd();
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_key = '0; col_start = 1'b0;
    col_wr = 1'b0; col_addr = '0; burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(col_valid), 32'd0);
    chk("R1 last in reset", 32'(col_last), 32'd0);
    chk("R1 latency in reset", 32'(cas_lat), 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(col_valid), 32'd0);

    // R1 / R12: reset mode gives a one-beat burst
    start_cmd(10'h055, 1'b0);
    chk("R12 reset-mode beat", 32'(col_out), 32'h055);
    chk("R12 reset-mode last", 32'(col_last), 32'd1);
    @(negedge clk);
    chk("R12 reset-mode end", 32'(col_valid), 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      load_mode(VEC[v].key);
      chk("R2 latency after load", 32'(cas_lat), 32'(VEC[v].cl));
      start_cmd(VEC[v].col, VEC[v].wr);
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        chk("R3 beat valid", 32'(col_valid), 32'd1);
        chk("R4 R5 beat column", 32'(col_out), 32'(VEC[v].a[i]));
        chk("R6 last flag", 32'(col_last), (i == int'(VEC[v].n) - 1) ? 32'd1 : 32'd0);
        @(negedge clk);
      end
      chk("R6 end of burst", 32'(col_valid), 32'd0);
    end

    // R2: reserved latency code keeps 3; then 2 then reserved keeps 2
    load_mode(13'h073);
    chk("R2 reserved latency keeps 3", 32'(cas_lat), 32'd3);
    load_mode(13'h023);
    load_mode(13'h003);
    chk("R2 reserved latency keeps 2", 32'(cas_lat), 32'd2);

    // R7: full page, wraps modulo 1024, never last, runs past 1024 beats
    load_mode(13'h037);
    start_cmd(10'h3FD, 1'b0);
    begin
      int bad = 0;
      for (int i = 0; i < 1030; i++) begin
        if (col_valid !== 1'b1 || col_last !== 1'b0 ||
            col_out !== 10'((10'h3FD + i) % 1024)) begin
          bad++;
          if (bad == 1)
            $display("FAIL R7 beat %0d actual=%0h/%0b/%0b expected=%0h/1/0", i, col_out,
                     col_valid, col_last, 10'((10'h3FD + i) % 1024));
        end
        if (i == 1029) burst_stop = 1'b1;
        @(negedge clk);
      end
      checks++;
      if (bad != 0) fails++;
      burst_stop = 1'b0;
      chk("R8 stop ends full page", 32'(col_valid), 32'd0);
    end

    // R7: order bit ignored in full page
    load_mode(13'h03F);
    start_cmd(10'h3FE, 1'b0);
    chk("R7 ilv ignored b0", 32'(col_out), 32'h3FE);
    @(negedge clk);
    chk("R7 ilv ignored b1", 32'(col_out), 32'h3FF);
    @(negedge clk);
    chk("R7 ilv ignored b2", 32'(col_out), 32'h000);
    stop_cmd();
    chk("R8 stop", 32'(col_valid), 32'd0);

    // R8: stop mid-burst at beat 1
    load_mode(13'h033);
    start_cmd(10'h040, 1'b0);
    @(negedge clk);
    chk("R8 beat1 before stop", 32'(col_out), 32'h041);
    stop_cmd();
    chk("R8 stop mid-burst", 32'(col_valid), 32'd0);
    // R8: stop while idle has no effect
    stop_cmd();
    chk("R8 idle stop", 32'(col_valid), 32'd0);
    chk("R8 idle stop last", 32'(col_last), 32'd0);

    // R9: new command with simultaneous stop at beat 2
    start_cmd(10'h040, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 beat2 before interrupt", 32'(col_out), 32'h042);
    burst_stop = 1'b1;
    start_cmd(10'h123, 1'b0);
    burst_stop = 1'b0;
    chk("R9 new burst valid", 32'(col_valid), 32'd1);
    chk("R9 new burst first", 32'(col_out), 32'h123);
    @(negedge clk);
    chk("R9 new burst second", 32'(col_out), 32'h124);
    stop_cmd();

    // R11: mode load during burst does not change it
    start_cmd(10'h010, 1'b0);
    load_mode(13'h03A);
    for (int i = 1; i < 8; i++) begin
      chk("R11 beat column", 32'(col_out), 32'(10'h010 + i));
      chk("R11 last", 32'(col_last), (i == 7) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    chk("R11 end", 32'(col_valid), 32'd0);
    // new mode applies to the next burst (len4 interleaved, latency 3)
    start_cmd(10'h012, 1'b0);
    chk("R11 new mode b0", 32'(col_out), 32'h012);
    @(negedge clk);
    chk("R11 new mode b1", 32'(col_out), 32'h013);
    @(negedge clk);
    chk("R11 new mode b2", 32'(col_out), 32'h010);

    repeat (6) @(negedge clk);
    finish_run();
  end

endmodule